// File: doc/BRIEF.md
# Byte-Addressed Call Stack Engine

This block is the stack unit of a small processor model. It keeps a 16-bit stack pointer, a saved frame (base) pointer and a byte-wide stack memory. The surrounding core hands it one stack operation at a time. The operations are: push or pop a word, push a near or far return address, save or restore the frame pointer, read a word at a frame-relative offset, and return. A return pops the return address and can then drop a number of parameter bytes given by the caller. Words are stored little-endian. A word at address A keeps its low byte at A and its high byte at A+1.

Commands arrive on a valid/ready handshake. The command side applies back-pressure only while a two-word operation (far call or far return) is in its second cycle. During that cycle `busy` is high and `in_ready` is low. The holder of a command keeps `in_valid`, `op` and `operand` stable until it sees `in_ready`. The result side has no back-pressure. Every accepted command produces exactly one `res_valid` pulse, which carries the popped word and the status flags. The consumer must take that pulse when it appears. A command that would cross the configured lower limit or the initial top of stack is refused, and the pointers and memory stay as they were.

Top module: `callstack_unit`

## Requirements
- R1: A word push (op 1) lowers SP by 2 and writes the operand with its low byte at the new SP and its high byte at SP+1. A frame read at an odd offset therefore returns bytes from two neighbouring words in little-endian order.
- R2: A word pop (op 2) returns the word at SP on `res_data` and raises SP by 2.
- R3: A push, call or frame save that would take SP below `LIMIT_SP` is refused. `ovf_o` is raised with `res_valid`, and SP, BP and the stacked data are unchanged.
- R4: A pop, frame restore or return that would take SP above `TOP_SP` is refused. `unf_o` is raised with `res_valid`, and SP is unchanged.
- R5: A near call (op 3) pushes `ret_off`, so SP drops by 2. A far call (op 4) pushes `ret_seg` and then `ret_off`, so the offset sits at the lower address. SP drops by 4 over two cycles, with `busy` high in the second cycle.
- R6: A frame save (op 5) pushes BP and then loads BP with the new SP. A frame restore (op 6) pops the top word into BP and also returns it on `res_data`.
- R7: A frame read (op 7) returns the word at BP+operand and leaves SP unchanged.
- R8: A read relative to SP (op 8) is rejected. `err_o` is raised with `res_valid`, and no state changes.
- R9: A near return (op 9) pops the offset. A far return (op 10) pops the offset and then the segment (on `res_seg`). Each then adds the operand byte count to SP. A count of 0 leaves SP lower than before the call by the bytes pushed as parameters.
- R10: A return with an odd byte count raises `err_o` and leaves SP unchanged.
- R11: A command is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low whenever `busy` is high. Each taken command yields exactly one `res_valid` pulse. The pulse comes in the cycle after acceptance, or one cycle later for a far call or far return.
- R12: After reset, SP equals `TOP_SP` and BP is 0. `busy` and `res_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command valid |
| in_ready | output | 1 | Command can be taken |
| op | input | 4 | Operation code (see requirements) |
| operand | input | 16 | Push data, frame offset or return byte count |
| ret_seg | input | 16 | Segment part of the return address for calls |
| ret_off | input | 16 | Offset part of the return address for calls |
| busy | output | 1 | Second cycle of a two-word operation in progress |
| sp_o | output | 16 | Current stack pointer |
| bp_o | output | 16 | Current frame pointer |
| res_valid | output | 1 | One-cycle completion pulse |
| res_data | output | 16 | Popped word, frame read word or return offset |
| res_seg | output | 16 | Segment popped by the last far return |
| err_o | output | 1 | Rejected command (SP-relative read or odd count) |
| ovf_o | output | 1 | Command refused for crossing the lower limit |
| unf_o | output | 1 | Command refused for crossing the top of stack |

## Verification
The bench replays a full parameter-passing frame. It pushes three words, makes a far call and saves the frame pointer. It then reads each parameter, the return address and the saved pointer back at their frame offsets. A design that put the segment below the offset, or that counted offsets from SP instead of BP, would return the wrong words there. A design that stored words big-endian would fail the odd-offset read. Plain returns and returns with a count are checked for the exact final SP, which catches a missing or doubled count. Refusals at both bounds and for odd counts are probed by reading the stack back afterwards: a design that half-applied a refused far call or return would leave SP moved.

// File: rtl/cstk_pkg.sv
package cstk_pkg;

  typedef enum logic [3:0] {
    OP_NOP        = 4'd0,
    OP_PUSH       = 4'd1,
    OP_POP        = 4'd2,
    OP_CALL_NEAR  = 4'd3,
    OP_CALL_FAR   = 4'd4,
    OP_FRAME_SAVE = 4'd5,
    OP_FRAME_REST = 4'd6,
    OP_FRAME_RD   = 4'd7,
    OP_SP_RD      = 4'd8,
    OP_RET_NEAR   = 4'd9,
    OP_RET_FAR    = 4'd10
  } cstk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FAR_CALL = 2'd1,
    ST_FAR_RET  = 2'd2
  } cstk_state_e;

endpackage

// File: rtl/cstk_bytemem.sv
module cstk_bytemem #(
  parameter int ADDR_W = 16,
  parameter int MEM_AW = 9,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int NBYTE = WORD_W / 8;

  logic [7:0] mem [DEPTH];

  logic [MEM_AW-1:0] wa;
  logic [MEM_AW-1:0] ra;
  assign wa = waddr[MEM_AW-1:0];
  assign ra = raddr[MEM_AW-1:0];

  // Byte b of a word lives at base+b: little-endian layout.
  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < NBYTE; b++) begin
        mem[wa + MEM_AW'(b)] <= wdata[8*b +: 8];
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NBYTE; b++) begin
      rdata[8*b +: 8] = mem[ra + MEM_AW'(b)];
    end
  end

endmodule

// File: rtl/cstk_bounds.sv
module cstk_bounds #(
  parameter int              SP_W     = 16,
  parameter logic [SP_W-1:0] TOP_SP   = 16'h17FE,
  parameter logic [SP_W-1:0] LIMIT_SP = 16'h1700
) (
  input  logic [SP_W-1:0] sp,
  input  logic [SP_W-1:0] dec_amt,
  input  logic [SP_W:0]   inc_amt,
  output logic            would_ovf,
  output logic            would_unf
);
  localparam int XW = SP_W + 2;

  logic [XW-1:0] sp_x;
  logic [XW-1:0] lim_need;
  logic [XW-1:0] sp_after_inc;

  assign sp_x         = {2'b00, sp};
  assign lim_need     = {2'b00, LIMIT_SP} + {2'b00, dec_amt};
  assign sp_after_inc = sp_x + {1'b0, inc_amt};

  assign would_ovf = sp_x < lim_need;
  assign would_unf = sp_after_inc > {2'b00, TOP_SP};

endmodule

// File: rtl/callstack_unit.sv
module callstack_unit
  import cstk_pkg::*;
#(
  parameter int              SP_W     = 16,
  parameter int              MEM_AW   = 9,
  parameter logic [SP_W-1:0] TOP_SP   = 16'h17FE,
  parameter logic [SP_W-1:0] LIMIT_SP = 16'h1700
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      op,
  input  logic [SP_W-1:0] operand,
  input  logic [SP_W-1:0] ret_seg,
  input  logic [SP_W-1:0] ret_off,
  output logic            busy,
  output logic [SP_W-1:0] sp_o,
  output logic [SP_W-1:0] bp_o,
  output logic            res_valid,
  output logic [SP_W-1:0] res_data,
  output logic [SP_W-1:0] res_seg,
  output logic            err_o,
  output logic            ovf_o,
  output logic            unf_o
);
  localparam int              WORD_BYTES = SP_W / 8;
  localparam logic [SP_W-1:0] WSTEP      = SP_W'(WORD_BYTES);
  localparam logic [SP_W-1:0] WSTEP2     = SP_W'(2 * WORD_BYTES);

  cstk_state_e     state;
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] bp;
  logic [SP_W-1:0] off_hold;
  logic [SP_W-1:0] cnt_hold;

  cstk_op_e opc;
  logic     fire;
  logic     odd_cnt;

  assign opc      = cstk_op_e'(op);
  assign busy     = (state != ST_IDLE);
  assign in_ready = !busy;
  assign fire     = in_valid && in_ready;
  assign odd_cnt  = operand[0];
  assign sp_o     = sp;
  assign bp_o     = bp;

  // ---- bound checks for the command being offered ----
  logic [SP_W-1:0] dec_amt;
  logic [SP_W:0]   inc_amt;
  logic            would_ovf;
  logic            would_unf;

  always_comb begin
    dec_amt = '0;
    inc_amt = '0;
    case (opc)
      OP_PUSH, OP_CALL_NEAR, OP_FRAME_SAVE: dec_amt = WSTEP;
      OP_CALL_FAR:                          dec_amt = WSTEP2;
      OP_POP, OP_FRAME_REST:                inc_amt = {1'b0, WSTEP};
      OP_RET_NEAR:                          inc_amt = {1'b0, operand} + {1'b0, WSTEP};
      OP_RET_FAR:                           inc_amt = {1'b0, operand} + {1'b0, WSTEP2};
      default: ;
    endcase
  end

  cstk_bounds #(
    .SP_W    (SP_W),
    .TOP_SP  (TOP_SP),
    .LIMIT_SP(LIMIT_SP)
  ) u_bounds (
    .sp       (sp),
    .dec_amt  (dec_amt),
    .inc_amt  (inc_amt),
    .would_ovf(would_ovf),
    .would_unf(would_unf)
  );

  // ---- memory port steering ----
  logic            mem_we;
  logic [SP_W-1:0] mem_waddr;
  logic [SP_W-1:0] mem_wdata;
  logic [SP_W-1:0] mem_raddr;
  logic [SP_W-1:0] mem_rdata;

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = sp - WSTEP;
    mem_wdata = operand;
    if (state == ST_FAR_CALL) begin
      mem_we    = 1'b1;
      mem_wdata = off_hold;
    end else if (fire && !would_ovf) begin
      case (opc)
        OP_PUSH:       mem_we = 1'b1;
        OP_CALL_NEAR:  begin mem_we = 1'b1; mem_wdata = ret_off; end
        OP_CALL_FAR:   begin mem_we = 1'b1; mem_wdata = ret_seg; end
        OP_FRAME_SAVE: begin mem_we = 1'b1; mem_wdata = bp;      end
        default: ;
      endcase
    end
  end

  assign mem_raddr = (state == ST_IDLE && opc == OP_FRAME_RD) ? (bp + operand) : sp;

  cstk_bytemem #(
    .ADDR_W(SP_W),
    .MEM_AW(MEM_AW),
    .WORD_W(SP_W)
  ) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .raddr(mem_raddr),
    .rdata(mem_rdata)
  );

  // ---- sequencing ----
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sp        <= TOP_SP;
      bp        <= '0;
      off_hold  <= '0;
      cnt_hold  <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_seg   <= '0;
      err_o     <= 1'b0;
      ovf_o     <= 1'b0;
      unf_o     <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      err_o     <= 1'b0;
      ovf_o     <= 1'b0;
      unf_o     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fire) begin
            case (opc)
              OP_PUSH, OP_CALL_NEAR: begin
                res_valid <= 1'b1;
                if (would_ovf) ovf_o <= 1'b1;
                else           sp    <= sp - WSTEP;
              end
              OP_FRAME_SAVE: begin
                res_valid <= 1'b1;
                if (would_ovf) ovf_o <= 1'b1;
                else begin
                  sp <= sp - WSTEP;
                  bp <= sp - WSTEP;
                end
              end
              OP_CALL_FAR: begin
                if (would_ovf) begin
                  ovf_o     <= 1'b1;
                  res_valid <= 1'b1;
                end else begin
                  sp       <= sp - WSTEP;
                  off_hold <= ret_off;
                  state    <= ST_FAR_CALL;
                end
              end
              OP_POP, OP_FRAME_REST: begin
                res_valid <= 1'b1;
                if (would_unf) unf_o <= 1'b1;
                else begin
                  res_data <= mem_rdata;
                  sp       <= sp + WSTEP;
                  if (opc == OP_FRAME_REST) bp <= mem_rdata;
                end
              end
              OP_FRAME_RD: begin
                res_valid <= 1'b1;
                res_data  <= mem_rdata;
              end
              OP_SP_RD: begin
                res_valid <= 1'b1;
                err_o     <= 1'b1;
              end
              OP_RET_NEAR: begin
                res_valid <= 1'b1;
                if (odd_cnt)        err_o <= 1'b1;
                else if (would_unf) unf_o <= 1'b1;
                else begin
                  res_data <= mem_rdata;
                  sp       <= sp + WSTEP + operand;
                end
              end
              OP_RET_FAR: begin
                if (odd_cnt) begin
                  err_o     <= 1'b1;
                  res_valid <= 1'b1;
                end else if (would_unf) begin
                  unf_o     <= 1'b1;
                  res_valid <= 1'b1;
                end else begin
                  res_data <= mem_rdata;
                  cnt_hold <= operand;
                  sp       <= sp + WSTEP;
                  state    <= ST_FAR_RET;
                end
              end
              default: res_valid <= 1'b1;
            endcase
          end
        end
        ST_FAR_CALL: begin
          sp        <= sp - WSTEP;
          res_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_FAR_RET: begin
          res_seg   <= mem_rdata;
          sp        <= sp + WSTEP + cnt_hold;
          res_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cstk_chk.sv
module cstk_chk #(
  parameter int              SP_W     = 16,
  parameter logic [SP_W-1:0] TOP_SP   = 16'h17FE,
  parameter logic [SP_W-1:0] LIMIT_SP = 16'h1700
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [3:0]      op,
  input logic [SP_W-1:0] operand,
  input logic            busy,
  input logic [SP_W-1:0] sp_o,
  input logic            res_valid,
  input logic            err_o,
  input logic            ovf_o,
  input logic            unf_o
);
  logic fire;
  assign fire = in_valid && in_ready;

  p_push_step_r1: assert property (@(posedge clk) disable iff (rst)
    (fire && op == 4'd1) |=> (ovf_o || sp_o == $past(sp_o) - SP_W'(2)));

  p_pop_step_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && op == 4'd2) |=> (unf_o || sp_o == $past(sp_o) + SP_W'(2)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    sp_o >= LIMIT_SP);

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    sp_o <= TOP_SP);

  p_far_call_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && op == 4'd4) |=> (busy || ovf_o));

  p_frame_rd_keeps_sp_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && op == 4'd7) |=> $stable(sp_o));

  p_sp_rd_rejected_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && op == 4'd8) |=> (err_o && res_valid && $stable(sp_o)));

  p_odd_count_r10: assert property (@(posedge clk) disable iff (rst)
    (fire && (op == 4'd9 || op == 4'd10) && operand[0]) |=> (err_o && $stable(sp_o)));

  p_busy_stall_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);

endmodule

bind callstack_unit cstk_chk #(
  .SP_W    (SP_W),
  .TOP_SP  (TOP_SP),
  .LIMIT_SP(LIMIT_SP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .op       (op),
  .operand  (operand),
  .busy     (busy),
  .sp_o     (sp_o),
  .res_valid(res_valid),
  .err_o    (err_o),
  .ovf_o    (ovf_o),
  .unf_o    (unf_o)
);

// File: tb/callstack_unit_bench.sv
`timescale 1ns/1ps
module callstack_unit_bench;
  localparam logic [15:0] TOP = 16'h17FE;
  localparam logic [15:0] LIM = 16'h17F0;
  localparam logic [15:0] SEG = 16'h1234;
  localparam logic [15:0] OFF = 16'h0ABC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [15:0] operand = '0;
  logic        in_ready, busy, res_valid, err_o, ovf_o, unf_o;
  logic [15:0] sp_o, bp_o, res_data, res_seg;

  always #2 clk = ~clk;

  callstack_unit #(.SP_W(16), .MEM_AW(9), .TOP_SP(TOP), .LIMIT_SP(LIM)) u_callstack_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .operand(operand), .ret_seg(SEG), .ret_off(OFF), .busy(busy), .sp_o(sp_o),
    .bp_o(bp_o), .res_valid(res_valid), .res_data(res_data), .res_seg(res_seg),
    .err_o(err_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] o, input logic [15:0] a);
    @(negedge clk);
    in_valid = 1'b1; op = o; operand = a;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 20 && !res_valid; i++) @(negedge clk);
    chk("R11", "res_valid pulse", {15'd0, res_valid}, 16'd1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // op, arg, exp sp, exp bp, exp data, check data, flags {err,ovf,unf}
  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] arg;
    logic [15:0] sp;
    logic [15:0] bp;
    logic [15:0] data;
    logic        cd;
    logic [2:0]  fl;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  16'h25F1, 16'h17FC, 16'h0000, 16'h0000, 1'b0, 3'b000}, // R1
    '{4'd1,  16'h1979, 16'h17FA, 16'h0000, 16'h0000, 1'b0, 3'b000},
    '{4'd1,  16'h3F62, 16'h17F8, 16'h0000, 16'h0000, 1'b0, 3'b000},
    '{4'd4,  16'h0000, 16'h17F4, 16'h0000, 16'h0000, 1'b0, 3'b000}, // R5
    '{4'd5,  16'h0000, 16'h17F2, 16'h17F2, 16'h0000, 1'b0, 3'b000}, // R6
    '{4'd7,  16'd6,    16'h17F2, 16'h17F2, 16'h3F62, 1'b1, 3'b000}, // R7
    '{4'd7,  16'd8,    16'h17F2, 16'h17F2, 16'h1979, 1'b1, 3'b000},
    '{4'd7,  16'd10,   16'h17F2, 16'h17F2, 16'h25F1, 1'b1, 3'b000},
    '{4'd7,  16'd2,    16'h17F2, 16'h17F2, 16'h0ABC, 1'b1, 3'b000}, // R5 offset low
    '{4'd7,  16'd4,    16'h17F2, 16'h17F2, 16'h1234, 1'b1, 3'b000}, // R5 segment high
    '{4'd7,  16'd0,    16'h17F2, 16'h17F2, 16'h0000, 1'b1, 3'b000}, // R6 saved BP
    '{4'd8,  16'd4,    16'h17F2, 16'h17F2, 16'h0000, 1'b0, 3'b100}, // R8
    '{4'd6,  16'h0000, 16'h17F4, 16'h0000, 16'h0000, 1'b1, 3'b000}, // R6 restore
    '{4'd10, 16'd5,    16'h17F4, 16'h0000, 16'h0000, 1'b0, 3'b100}, // R10
    '{4'd10, 16'd6,    16'h17FE, 16'h0000, 16'h0ABC, 1'b1, 3'b000}, // R9 far ret count
    '{4'd2,  16'h0000, 16'h17FE, 16'h0000, 16'h0000, 1'b0, 3'b001}, // R4 pop at top
    '{4'd1,  16'h1111, 16'h17FC, 16'h0000, 16'h0000, 1'b0, 3'b000},
    '{4'd3,  16'h0000, 16'h17FA, 16'h0000, 16'h0000, 1'b0, 3'b000}, // R5 near call
    '{4'd9,  16'd0,    16'h17FC, 16'h0000, 16'h0ABC, 1'b1, 3'b000}, // R9 plain ret leaks
    '{4'd2,  16'h0000, 16'h17FE, 16'h0000, 16'h1111, 1'b1, 3'b000}, // R2
    '{4'd1,  16'hA1B2, 16'h17FC, 16'h0000, 16'h0000, 1'b0, 3'b000},
    '{4'd1,  16'hC3D4, 16'h17FA, 16'h0000, 16'h0000, 1'b0, 3'b000},
    '{4'd5,  16'h0000, 16'h17F8, 16'h17F8, 16'h0000, 1'b0, 3'b000},
    '{4'd7,  16'd3,    16'h17F8, 16'h17F8, 16'hB2C3, 1'b1, 3'b000}, // R1 byte order
    '{4'd6,  16'h0000, 16'h17FA, 16'h0000, 16'h0000, 1'b1, 3'b000},
    '{4'd9,  16'd8,    16'h17FA, 16'h0000, 16'h0000, 1'b0, 3'b001}, // R4 count past top
    '{4'd2,  16'h0000, 16'h17FC, 16'h0000, 16'hC3D4, 1'b1, 3'b000}, // R2
    '{4'd2,  16'h0000, 16'h17FE, 16'h0000, 16'hA1B2, 1'b1, 3'b000}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "sp", sp_o, TOP);
    chk("R12", "bp", bp_o, 16'h0000);
    chk("R12", "in_ready/busy/res_valid", {13'd0, in_ready, busy, res_valid}, 16'b100);

    for (int k = 0; k < NV; k++) begin
      do_op(VEC[k].op, VEC[k].arg);
      chk("R1-vector sp", $sformatf("vec %0d sp", k), sp_o, VEC[k].sp);
      chk("R6", $sformatf("vec %0d bp", k), bp_o, VEC[k].bp);
      chk("R3 R4 R8 R10", $sformatf("vec %0d flags", k), {13'd0, err_o, ovf_o, unf_o}, {13'd0, VEC[k].fl});
      if (VEC[k].cd) chk("R7 R9", $sformatf("vec %0d data", k), res_data, VEC[k].data);
      if (VEC[k].op == 4'd10 && VEC[k].fl == 3'b000) chk("R9", "far return segment", res_seg, SEG);
    end

    // R5 / R11: far call busy window
    do_reset();
    @(negedge clk);
    in_valid = 1'b1; op = 4'd4; operand = '0;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11", "busy,in_ready,res_valid mid far call", {13'd0, busy, in_ready, res_valid}, 16'b100);
    chk("R5", "sp mid far call", sp_o, 16'h17FC);
    @(negedge clk);
    chk("R11", "busy,res_valid end far call", {14'd0, busy, res_valid}, 16'b01);
    chk("R5", "sp after far call", sp_o, 16'h17FA);

    // R3 overflow refusals
    do_reset();
    for (int k = 0; k < 6; k++) do_op(4'd1, 16'h5000 + 16'(k));
    chk("R3", "sp after six pushes", sp_o, 16'h17F2);
    do_op(4'd4, 16'h0000);
    chk("R3", "far call ovf flag", {15'd0, ovf_o}, 16'd1);
    chk("R3", "far call refused sp", sp_o, 16'h17F2);
    do_op(4'd1, 16'h6666);
    chk("R3", "last legal push sp", sp_o, LIM);
    do_op(4'd1, 16'h7777);
    chk("R3", "push ovf flag", {15'd0, ovf_o}, 16'd1);
    chk("R3", "push refused sp", sp_o, LIM);
    do_op(4'd5, 16'h0000);
    chk("R3", "frame save refused bp", bp_o, 16'h0000);
    do_op(4'd2, 16'h0000);
    chk("R3", "top word intact", res_data, 16'h6666);

    // R4 far return past top
    do_reset();
    do_op(4'd10, 16'd0);
    chk("R4", "far ret unf flag", {15'd0, unf_o}, 16'd1);
    chk("R4", "far ret refused sp", sp_o, TOP);
    chk("R11", "busy after refused far ret", {15'd0, busy}, 16'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule